// File: doc/BRIEF.md
# Two-Stage Min/Max Merge Unit

This block does a three-operand integer operation in one pass. In the first stage it takes the smaller or the larger of two 32-bit operands A and B. The comparison is signed or unsigned, and the result can be saturated. In the second stage it combines that intermediate value with a third operand C. It can insert a lane of the intermediate into C, add the two, take a further min or max against C, or pass the intermediate through unchanged. A max followed by a second max gives a three-input maximum in one operation, and the same holds for minimum.

Each request is presented with `in_valid`. The answer appears one clock later on `result` together with `out_valid`. Requests whose source format is narrower than a full word, or whose two sources disagree on signedness, are not computed. Such requests raise `unsupported` and return zero.

Top module: `minmax_merge_unit`

## Requirements
- R1: The first stage picks max(A, B) when `sel_max` is 1 and min(A, B) when it is 0. It compares as two's-complement when `a_signed` is 1 and as unsigned otherwise.
- R2: When `saturate` is 1, the intermediate is clamped as follows. A negative intermediate from signed sources becomes 0 when `dst_signed` is 0 and is kept when `dst_signed` is 1. An intermediate from unsigned sources above 0x7FFFFFFF becomes 0x7FFFFFFF. When `saturate` is 0, the intermediate is never altered.
- R3: `sec_op` codes 0 to 3 insert the low bits of the intermediate into C and keep all other bits of C. Code 0 writes 16 bits at C[31:16]. Code 1 writes 16 bits at C[15:0]. Code 2 writes 8 bits at C[7:0]. Code 3 writes 8 bits at C[23:16].
- R4: `sec_op` code 4 outputs intermediate + C modulo 2^32.
- R5: `sec_op` code 5 outputs min(intermediate, C) and code 6 outputs max(intermediate, C). Both compare signed when `dst_signed` is 1 and unsigned otherwise, regardless of `a_signed`. Code 7 outputs the intermediate unchanged.
- R6: A request is unsupported in three cases: `a_fmt` is not 0, `b_fmt` is not 0, or `a_signed` differs from `b_signed`. Format code 0 means a full 32-bit word; any other code is a narrower format. For an unsupported request `unsupported` is 1 and `result` is 0. Otherwise `unsupported` is 0.
- R7: `out_valid` equals `in_valid` of the previous cycle. `result` and `unsupported` belong to the request accepted on the previous edge, so requests can be issued back to back.
- R8: While `in_valid` is 0, `result` and `unsupported` hold their last values.
- R9: While `rst` is high, `out_valid`, `result` and `unsupported` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| src_a | input | 32 | Operand A |
| src_b | input | 32 | Operand B |
| src_c | input | 32 | Operand C for the second stage |
| sel_max | input | 1 | First stage: 1 = max, 0 = min |
| a_signed | input | 1 | Signedness of A; also sets first-stage compare |
| b_signed | input | 1 | Signedness of B |
| dst_signed | input | 1 | Signedness for saturation and second-stage min/max |
| saturate | input | 1 | Enable clamping of the intermediate |
| a_fmt | input | 2 | Source format of A, 0 = 32-bit word |
| b_fmt | input | 2 | Source format of B, 0 = 32-bit word |
| sec_op | input | 3 | Second-stage operation code |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| unsupported | output | 1 | Request could not be executed |

## Verification
The bench uses operands that sit on both sides of the sign bit. A unit that mixed up signed and unsigned compares, in either stage, would return the other operand. It also covers the second stage comparing with the source flag instead of the destination flag. The merge cases use a C with a distinct value in every byte, so a shifted lane or a clobbered neighbour shows up at once. Other cases cover an accumulate that overflows, and saturation of values that are negative or just above the signed maximum. Sign-mismatch and narrow-format requests are checked for the zeroed result. The bench also checks that the flag clears again on the next good request, and that output is held over idle cycles.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

  localparam int FMT_W = 2;
  localparam logic [FMT_W-1:0] FMT_WORD = '0;

  typedef enum logic [2:0] {
    SEC_INS_HI16 = 3'd0,
    SEC_INS_LO16 = 3'd1,
    SEC_INS_B0   = 3'd2,
    SEC_INS_B2   = 3'd3,
    SEC_ADD      = 3'd4,
    SEC_MIN      = 3'd5,
    SEC_MAX      = 3'd6,
    SEC_PASS     = 3'd7
  } sec_op_e;

  localparam int NUM_INS = 4;

endpackage

// File: rtl/mmx_pair_select.sv
module mmx_pair_select #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             pick_max,
  input  logic             cmp_signed,
  input  logic             dst_signed,
  input  logic             clamp_en,
  output logic [WIDTH-1:0] mid
);

  localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};

  logic             a_lt_b;
  logic [WIDTH-1:0] raw;
  logic             raw_neg;
  logic             raw_big;

  always_comb begin
    if (cmp_signed) a_lt_b = $signed(op_a) < $signed(op_b);
    else            a_lt_b = op_a < op_b;
  end

  always_comb begin
    if (pick_max) raw = a_lt_b ? op_b : op_a;
    else          raw = a_lt_b ? op_a : op_b;
  end

  assign raw_neg = cmp_signed & raw[WIDTH-1];
  assign raw_big = ~cmp_signed & raw[WIDTH-1];

  always_comb begin
    mid = raw;
    if (clamp_en) begin
      if (raw_neg && !dst_signed) mid = '0;
      else if (raw_big)           mid = POS_MAX;
    end
  end

  // R1: without clamping the intermediate is one of the two operands
  always_comb begin
    if (!clamp_en) begin
      a_r1_from_operand: assert (mid == op_a || mid == op_b)
        else $error("first stage produced a value outside {A,B}");
    end
  end

  // R2: a clamped unsigned-destination result never has the sign bit set
  always_comb begin
    if (clamp_en && !dst_signed) begin
      a_r2_clamp_range: assert (mid[WIDTH-1] == 1'b0)
        else $error("saturated value out of range");
    end
  end

endmodule

// File: rtl/mmx_combine.sv
module mmx_combine
  import mmx_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] mid,
  input  logic [WIDTH-1:0] op_c,
  input  sec_op_e          op,
  input  logic             dst_signed,
  output logic [WIDTH-1:0] res
);

  localparam int HALF = WIDTH / 2;
  localparam int QUAR = WIDTH / 4;

  logic [NUM_INS*WIDTH-1:0] ins_flat;

  for (genvar k = 0; k < NUM_INS; k++) begin : g_ins
    localparam int LO = (k == 0) ? HALF : (k == 3) ? HALF : 0;
    localparam int LW = (k < 2) ? HALF : QUAR;
    logic [WIDTH-1:0] lane_word;
    always_comb begin
      lane_word = op_c;
      lane_word[LO +: LW] = mid[LW-1:0];
    end
    assign ins_flat[k*WIDTH +: WIDTH] = lane_word;
  end

  logic             mid_lt_c;
  logic [WIDTH-1:0] sum;

  always_comb begin
    if (dst_signed) mid_lt_c = $signed(mid) < $signed(op_c);
    else            mid_lt_c = mid < op_c;
  end

  assign sum = mid + op_c;

  always_comb begin
    unique case (op)
      SEC_INS_HI16: res = ins_flat[0*WIDTH +: WIDTH];
      SEC_INS_LO16: res = ins_flat[1*WIDTH +: WIDTH];
      SEC_INS_B0:   res = ins_flat[2*WIDTH +: WIDTH];
      SEC_INS_B2:   res = ins_flat[3*WIDTH +: WIDTH];
      SEC_ADD:      res = sum;
      SEC_MIN:      res = mid_lt_c ? mid : op_c;
      SEC_MAX:      res = mid_lt_c ? op_c : mid;
      default:      res = mid;
    endcase
  end

  // R3: insertion into the upper half leaves the lower half of C intact
  always_comb begin
    if (op == SEC_INS_HI16) begin
      a_r3_hi_keeps_low: assert (res[HALF-1:0] == op_c[HALF-1:0])
        else $error("merge-high disturbed low half of C");
    end
    if (op == SEC_INS_B0) begin
      a_r3_b0_keeps_rest: assert (res[WIDTH-1:QUAR] == op_c[WIDTH-1:QUAR])
        else $error("merge-byte0 disturbed upper bits of C");
    end
  end

  // R5: second-stage min/max returns one of its inputs
  always_comb begin
    if (op == SEC_MIN || op == SEC_MAX) begin
      a_r5_from_inputs: assert (res == mid || res == op_c)
        else $error("second-stage min/max produced a foreign value");
    end
  end

endmodule

// File: rtl/mmx_format_check.sv
module mmx_format_check
  import mmx_pkg::*;
(
  input  logic [FMT_W-1:0] fmt_a,
  input  logic [FMT_W-1:0] fmt_b,
  input  logic             sgn_a,
  input  logic             sgn_b,
  output logic             bad
);

  logic narrow;
  logic sign_clash;

  assign narrow     = (fmt_a != FMT_WORD) || (fmt_b != FMT_WORD);
  assign sign_clash = sgn_a ^ sgn_b;
  assign bad        = narrow | sign_clash;

endmodule

// File: rtl/minmax_merge_unit.sv
module minmax_merge_unit
  import mmx_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [WIDTH-1:0] src_c,
  input  logic             sel_max,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic             dst_signed,
  input  logic             saturate,
  input  logic [1:0]       a_fmt,
  input  logic [1:0]       b_fmt,
  input  logic [2:0]       sec_op,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             unsupported
);

  logic [WIDTH-1:0] mid;
  logic [WIDTH-1:0] comb_res;
  logic             req_bad;

  mmx_format_check u_fmt (
    .fmt_a (a_fmt),
    .fmt_b (b_fmt),
    .sgn_a (a_signed),
    .sgn_b (b_signed),
    .bad   (req_bad)
  );

  mmx_pair_select #(.WIDTH(WIDTH)) u_first (
    .op_a       (src_a),
    .op_b       (src_b),
    .pick_max   (sel_max),
    .cmp_signed (a_signed),
    .dst_signed (dst_signed),
    .clamp_en   (saturate),
    .mid        (mid)
  );

  mmx_combine #(.WIDTH(WIDTH)) u_second (
    .mid        (mid),
    .op_c       (src_c),
    .op         (sec_op_e'(sec_op)),
    .dst_signed (dst_signed),
    .res        (comb_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      unsupported <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= req_bad ? '0 : comb_res;
        unsupported <= req_bad;
      end
    end
  end

  // R7: valid is the request strobe delayed by one cycle
  a_r7_valid_delay: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)))
    else $error("out_valid not aligned to in_valid");

  // R6: an unsupported answer carries a zero result
  a_r6_unsup_zero: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> (result == '0))
    else $error("unsupported request returned nonzero data");

  // R8: outputs are frozen across idle cycles
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(result) && $stable(unsupported)))
    else $error("output changed without a request");

endmodule

// File: tb/minmax_merge_unit_test.sv
module minmax_merge_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] src_a, src_b, src_c;
  logic        sel_max, a_signed, b_signed, dst_signed, saturate;
  logic [1:0]  a_fmt, b_fmt;
  logic [2:0]  sec_op;
  logic        out_valid;
  logic [31:0] result;
  logic        unsupported;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  minmax_merge_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .sel_max(sel_max), .a_signed(a_signed), .b_signed(b_signed),
    .dst_signed(dst_signed), .saturate(saturate),
    .a_fmt(a_fmt), .b_fmt(b_fmt), .sec_op(sec_op),
    .out_valid(out_valid), .result(result), .unsupported(unsupported)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Apply one request at a falling edge, read the answer at the next falling edge.
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic mx, input logic sgn, input logic ds, input logic sat,
                       input logic [2:0] op);
    in_valid = 1'b1; src_a = a; src_b = b; src_c = c;
    sel_max = mx; a_signed = sgn; b_signed = sgn; dst_signed = ds; saturate = sat;
    a_fmt = 2'd0; b_fmt = 2'd0; sec_op = op;
    @(negedge clk);
  endtask

  task automatic expect_ok(input string req, input logic [31:0] exp);
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, result, exp);
    check(req, {31'd0, unsupported}, 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0;
    src_a = '0; src_b = '0; src_c = '0; sel_max = 0; a_signed = 0; b_signed = 0;
    dst_signed = 0; saturate = 0; a_fmt = 0; b_fmt = 0; sec_op = 3'd7;
    repeat (3) @(negedge clk);
    check("R9 out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 result", result, 32'd0);
    check("R9 unsupported", {31'd0, unsupported}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_first_stage;
    issue(32'h8000_0000, 32'd5, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7);
    expect_ok("R1 unsigned min", 32'd5);
    issue(32'h8000_0000, 32'd5, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7);
    expect_ok("R1 unsigned max", 32'h8000_0000);
    issue(32'h8000_0000, 32'd5, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd7);
    expect_ok("R1 signed min", 32'h8000_0000);
    issue(32'd5, 32'h8000_0000, 32'd0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd7);
    expect_ok("R1 signed max", 32'd5);
  endtask

  task automatic t_saturate;
    issue(32'hFFFF_FFF9, 32'hFFFF_FFFD, 32'd0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd7);
    expect_ok("R2 negative to zero", 32'd0);
    issue(32'hFFFF_FFF9, 32'hFFFF_FFFD, 32'd0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd7);
    expect_ok("R2 negative kept for signed dst", 32'hFFFF_FFFD);
    issue(32'hFFFF_FFF9, 32'hFFFF_FFFD, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd7);
    expect_ok("R2 no clamp when off", 32'hFFFF_FFFD);
    issue(32'h9000_0000, 32'd1, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd7);
    expect_ok("R2 large unsigned clamped", 32'h7FFF_FFFF);
    issue(32'h8000_0000, 32'd1, 32'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd7);
    expect_ok("R2 boundary clamped signed dst", 32'h7FFF_FFFF);
    issue(32'h10, 32'd1, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd7);
    expect_ok("R2 small value untouched", 32'h10);
  endtask

  task automatic t_merge;
    issue(32'h1234_ABCD, 32'h1234_ABCD, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
    expect_ok("R3 insert high16", 32'hABCD_BEEF);
    issue(32'h1234_ABCD, 32'h1234_ABCD, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1);
    expect_ok("R3 insert low16", 32'hDEAD_ABCD);
    issue(32'h1234_ABCD, 32'h1234_ABCD, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2);
    expect_ok("R3 insert byte0", 32'hDEAD_BECD);
    issue(32'h1234_ABCD, 32'h1234_ABCD, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3);
    expect_ok("R3 insert byte2", 32'hDECD_BEEF);
  endtask

  task automatic t_accumulate;
    issue(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h20, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4);
    expect_ok("R4 wrapping add", 32'h10);
    issue(32'd7, 32'd9, 32'd100, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4);
    expect_ok("R4 plain add", 32'd109);
  endtask

  task automatic t_second_minmax;
    issue(32'd5, 32'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5);
    expect_ok("R5 min unsigned dst", 32'd5);
    issue(32'd5, 32'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 3'd5);
    expect_ok("R5 min signed dst", 32'hFFFF_FFFF);
    issue(32'd5, 32'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd6);
    expect_ok("R5 max unsigned dst", 32'hFFFF_FFFF);
    issue(32'd5, 32'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6);
    expect_ok("R5 max signed dst", 32'd5);
    issue(32'd3, 32'd8, 32'd6, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6);
    expect_ok("R5 three-input max", 32'd8);
    issue(32'd3, 32'd8, 32'hAAAA_5555, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7);
    expect_ok("R5 pass", 32'd8);
  endtask

  task automatic t_unsupported;
    issue(32'd1, 32'd2, 32'd3, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7);
    b_signed = 1'b1;
    // re-issue the same cycle's request with mismatched signs
    in_valid = 1'b1;
    @(negedge clk);
    check("R6 sign clash flag", {31'd0, unsupported}, 32'd1);
    check("R6 sign clash zero", result, 32'd0);
    issue(32'd1, 32'd2, 32'd3, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7);
    expect_ok("R6 flag clears", 32'd2);
    a_fmt = 2'd1;
    @(negedge clk);
    check("R6 narrow A flag", {31'd0, unsupported}, 32'd1);
    check("R6 narrow A zero", result, 32'd0);
    a_fmt = 2'd0; b_fmt = 2'd2;
    @(negedge clk);
    check("R6 narrow B flag", {31'd0, unsupported}, 32'd1);
  endtask

  task automatic t_timing;
    issue(32'd11, 32'd22, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7);
    expect_ok("R7 first of pair", 32'd22);
    issue(32'd11, 32'd22, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7);
    expect_ok("R7 second of pair", 32'd11);
    in_valid = 1'b0; src_a = 32'd99; src_b = 32'd99; sec_op = 3'd4; b_fmt = 2'd3;
    @(negedge clk);
    check("R7 valid drops", {31'd0, out_valid}, 32'd0);
    check("R8 result held", result, 32'd11);
    check("R8 flag held", {31'd0, unsupported}, 32'd0);
    @(negedge clk);
    check("R8 result held two cycles", result, 32'd11);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_stage();
    t_saturate();
    t_merge();
    t_accumulate();
    t_second_minmax();
    t_unsupported();
    t_timing();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule